// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block connects an on-chip request bus to an external asynchronous static RAM of 512K bytes. The RAM is driven through active-low chip-select, output-enable and write-enable strobes. Data travels on a shared bidirectional byte lane, which this block exposes as a split output, output-enable and input, with the pad sitting elsewhere. A client presents an address, a direction and write data while the block is idle. The block then runs one complete RAM cycle and signals its end with a one-cycle done pulse. For reads, the captured byte comes back with that pulse.

Each strobe phase is sized from the RAM's minimum nanosecond timings, which are turned into clock counts by rounding up against the clock period parameter. Writes are controlled by the write-enable strobe, and output-enable stays high for their whole length. The block enables its own data driver only after output-enable has been high long enough for the RAM to release the lane. The driver goes off one clock after write-enable rises.

Top module: `sramc_ctl`

## Requirements
- R1: During and right after synchronous reset, all three strobes are high, the data driver enable is 0, `req_ready` is 1 and `rsp_done` is 0.
- R2: A read holds chip-select and output-enable low and write-enable high for RD cycles. RD is the largest of ceil(cycle/clk), ceil(address access/clk) and ceil(output-enable access/clk), which is 7 at 8 ns. The cycle measured from chip-select fall to rise is at least 55 ns.
- R3: Read data is sampled from `sram_dq_in` on the last clock of the read phase. It appears on `rsp_rdata` together with `rsp_done`, which is visible in the cycle that follows RD clock edges after acceptance.
- R4: During a write, output-enable stays high and chip-select stays low. Write-enable is low for WP = max(ceil(40/clk), ceil(25/clk)) cycles, which is 5 at 8 ns.
- R5: The data driver is enabled only while chip-select is low and output-enable is high. It turns on only after an address phase of at least ceil(20/clk) cycles with output-enable high, and it turns off one clock after write-enable rises.
- R6: Write data is driven for at least 25 ns before write-enable rises, and it stays driven until at least that rising edge.
- R7: The address stays constant while chip-select is low. It is valid for at least 50 ns before the end of a write, and a whole write, from chip-select fall to rise, lasts at least 55 ns.
- R8: A request is accepted only while `req_ready` is high. A request raised while a cycle is in progress has no effect on the RAM.
- R9: `rsp_done` is a single-cycle pulse. For a write it is visible in the cycle that follows WA+WP+1 clock edges after acceptance, where WA = max(ceil(20/clk), ceil(50/clk)-WP, ceil(55/clk)-WP-1), which is 9 edges at 8 ns.
- R10: The block and the RAM never drive the data lane at the same time, including when a read and a write run back to back in either order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write byte |
| req_ready | output | 1 | Idle, a request will be taken on this edge |
| rsp_done | output | 1 | One-cycle end-of-cycle pulse |
| rsp_rdata | output | DATA_W | Captured read byte |
| sram_addr | output | ADDR_W | RAM address |
| sram_cs_n | output | 1 | Chip-select, active low |
| sram_oe_n | output | 1 | Output-enable, active low |
| sram_we_n | output | 1 | Write-enable, active low |
| sram_dq_out | output | DATA_W | Byte to drive onto the lane |
| sram_dq_oe | output | 1 | Lane driver enable |
| sram_dq_in | input | DATA_W | Byte sampled from the lane |

## Verification
Each request is accepted on a rising edge. The completion pulse is then due RD edges later for a read and WA+WP+1 edges later for a write, so the bench counts falling edges from the acceptance edge. It requires the pulse on exactly the count it computes from the nanosecond values, and requires it gone one cycle later. The RAM model timestamps every strobe, address and data change on a half-nanosecond grid. It returns inverted data until the access times have elapsed, so a capture that comes too early shows up as a data mismatch. On each strobe release it measures pulse width, setup and cycle length, and it flags any instant at which both sides drive the lane.

// File: rtl/sramc_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the SRAM strobe sequencer.
// Assumes timings are given as positive integer nanoseconds.
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WADDR,
        ST_WPULSE,
        ST_WREC
    } sramc_state_e;

    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic drv;
    } sramc_strobe_t;

    // Round a nanosecond figure up to whole clock periods.
    function automatic int cdiv(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Strobe levels for each phase of the sequence.
    function automatic sramc_strobe_t strobe_of(input sramc_state_e s);
        sramc_strobe_t r;
        case (s)
            ST_READ:   r = '{cs_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drv: 1'b0};
            ST_WADDR:  r = '{cs_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
            ST_WPULSE: r = '{cs_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drv: 1'b1};
            ST_WREC:   r = '{cs_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drv: 1'b1};
            default:   r = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sramc_seq.sv
`timescale 1ns/1ps
// Phase sequencer: walks idle -> read, or idle -> address -> pulse -> recovery,
// holding each phase for its parameter count. Strobes leave registers, so
// they cannot glitch. Assumes every count is at least 1 and fits in CNT_W.
module sramc_seq
    import sramc_pkg::*;
#(
    parameter int RD_CYC = 6,
    parameter int WA_CYC = 2,
    parameter int WP_CYC = 4,
    parameter int CNT_W  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    output logic req_ready,
    output logic accept,
    output logic capture,
    output logic done,
    output logic cs_n,
    output logic oe_n,
    output logic we_n,
    output logic dq_oe
);

    sramc_state_e   state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    sramc_strobe_t  stb_q;

    // Remaining-cycle load value for a phase about to be entered.
    function automatic logic [CNT_W-1:0] span(input sramc_state_e s);
        case (s)
            ST_READ:   return CNT_W'(RD_CYC - 1);
            ST_WADDR:  return CNT_W'(WA_CYC - 1);
            ST_WPULSE: return CNT_W'(WP_CYC - 1);
            default:   return '0;
        endcase
    endfunction

    // Next phase once the current one has run out.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (req_valid) state_d = req_write ? ST_WADDR : ST_READ;
            ST_READ:   if (cnt_q == '0) state_d = ST_IDLE;
            ST_WADDR:  if (cnt_q == '0) state_d = ST_WPULSE;
            ST_WPULSE: if (cnt_q == '0) state_d = ST_WREC;
            ST_WREC:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign capture   = (state_q == ST_READ) && (cnt_q == '0);

    // Phase register, its down-counter, registered strobes and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            stb_q   <= strobe_of(ST_IDLE);
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) cnt_q <= span(state_d);
            else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
            stb_q <= strobe_of(state_d);
            done  <= capture || (state_q == ST_WREC);
        end
    end

    assign cs_n  = stb_q.cs_n;
    assign oe_n  = stb_q.oe_n;
    assign we_n  = stb_q.we_n;
    assign dq_oe = stb_q.drv;

    // Checker counter: length of the current write-enable low run.
    logic [CNT_W-1:0] we_run;
    always_ff @(posedge clk) begin
        if (!rst_n)     we_run <= '0;
        else if (!we_n) we_run <= we_run + 1'b1;
        else            we_run <= '0;
    end

    AST_WE_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_run >= CNT_W'(WP_CYC)));                 // R4
    AST_WE_WITH_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (oe_n && !cs_n));                                  // R4
    AST_DRV_ONLY_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (oe_n && !cs_n));                                  // R5
    AST_DRV_HOLD_PAST_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> dq_oe);                                      // R6
    AST_DRV_OFF_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |=> !dq_oe);                                     // R5
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                             // R9
    AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> cs_n);                                         // R8

endmodule

// File: rtl/sramc_dpath.sv
`timescale 1ns/1ps
// Data path: latches address and write byte when a request is taken, and
// samples the lane into the read register on the sequencer's capture strobe.
// Assumes capture falls on the final clock of the read phase.
module sramc_dpath #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    // Hold request fields steady for the whole RAM cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Sample the RAM output at the end of the read phase.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (capture) rdata_q <= dq_in;
    end

    AST_RDATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rdata_q));                              // R3
    AST_ADDR_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(addr_q));                                // R7

endmodule

// File: rtl/sramc_ctl.sv
`timescale 1ns/1ps
// Top of the SRAM strobe sequencer. Converts the RAM's minimum timings into
// clock counts and wires the sequencer to the data path. Assumes the lane
// pad combines sram_dq_out/sram_dq_oe and feeds sram_dq_in back.
module sramc_ctl
    import sramc_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 8,
    parameter int CLK_NS   = 10,
    parameter int T_RC_NS  = 55,
    parameter int T_AA_NS  = 55,
    parameter int T_OE_NS  = 25,
    parameter int T_OHZ_NS = 20,
    parameter int T_WC_NS  = 55,
    parameter int T_WP_NS  = 40,
    parameter int T_AW_NS  = 50,
    parameter int T_DW_NS  = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);

    localparam int RD_CYC   = imax(imax(cdiv(T_RC_NS, CLK_NS), cdiv(T_AA_NS, CLK_NS)),
                                   imax(cdiv(T_OE_NS, CLK_NS), 1));
    localparam int TURN_CYC = cdiv(T_OHZ_NS, CLK_NS);
    localparam int WP_CYC   = imax(imax(cdiv(T_WP_NS, CLK_NS), cdiv(T_DW_NS, CLK_NS)), 1);
    localparam int WA_CYC   = imax(imax(TURN_CYC, 1),
                                   imax(cdiv(T_AW_NS, CLK_NS) - WP_CYC,
                                        cdiv(T_WC_NS, CLK_NS) - WP_CYC - 1));
    localparam int MAX_CYC  = imax(RD_CYC, imax(WA_CYC, WP_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1) + 1;

    logic accept, capture;

    sramc_seq #(
        .RD_CYC (RD_CYC),
        .WA_CYC (WA_CYC),
        .WP_CYC (WP_CYC),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .done      (rsp_done),
        .cs_n      (sram_cs_n),
        .oe_n      (sram_oe_n),
        .we_n      (sram_we_n),
        .dq_oe     (sram_dq_oe)
    );

    sramc_dpath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dq_in     (sram_dq_in),
        .addr_q    (sram_addr),
        .wdata_q   (sram_dq_out),
        .rdata_q   (rsp_rdata)
    );

    AST_ADDR_STABLE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));   // R7

endmodule

// File: tb/sramc_ctl_test.sv
`timescale 1ns/100ps
// Bench: RAM model with timing checks, directed corners, seeded random traffic.
module sramc_ctl_test;

    localparam int CLK_NS = 8;
    localparam int AW = 19;
    localparam int DW = 8;

    function automatic int up(input int ns); return (ns + CLK_NS - 1) / CLK_NS; endfunction
    function automatic int mx(input int a, input int b); return (a > b) ? a : b; endfunction

    localparam int E_RD  = mx(mx(up(55), up(55)), up(25));
    localparam int E_WP  = mx(up(40), up(25));
    localparam int E_WA  = mx(up(20), mx(up(50) - E_WP, up(55) - E_WP - 1));
    localparam int E_WT  = E_WA + E_WP + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] sram_addr;
    logic sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [DW-1:0] sram_dq_out, sram_dq_in;

    always #(CLK_NS/2) clk = ~clk;

    sramc_ctl #(.CLK_NS(CLK_NS)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
        .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    int checks = 0, errors = 0, clash = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- RAM model ----------------
    bit model_on = 0;
    logic [7:0] mem [int];
    logic [7:0] ref_mem [int];
    logic [7:0] ram_dq = 8'h00;
    bit ram_drv = 0;
    realtime t_addr = 0, t_cs_fall = 0, t_oe_fall = 0, t_rd_off = -100, t_wr_start = 0, t_data = 0;

    wire wr_act = !sram_cs_n && !sram_we_n;
    wire rd_act = !sram_cs_n && !sram_oe_n && sram_we_n;

    assign sram_dq_in = sram_dq_oe ? sram_dq_out : (ram_drv ? ram_dq : 8'hEE);

    always @(sram_addr) t_addr = $realtime;
    always @(sram_dq_out or sram_dq_oe) t_data = $realtime;
    always @(negedge sram_oe_n) t_oe_fall = $realtime;
    always @(negedge rd_act) t_rd_off = $realtime;
    always @(sram_cs_n) begin
        if (!sram_cs_n) t_cs_fall = $realtime;
        else if (model_on) chk("R7 cycle length ns>=55", 32'($realtime - t_cs_fall >= 55.0), 32'd1);
    end
    always @(wr_act) begin
        if (wr_act) t_wr_start = $realtime;
        else if (model_on) begin
            chk("R4 write pulse ns>=40", 32'($realtime - t_wr_start >= 40.0), 32'd1);
            chk("R6 data setup ns>=25 and driven", 32'(($realtime - t_data >= 25.0) && sram_dq_oe), 32'd1);
            chk("R7 address to end ns>=50", 32'($realtime - t_addr >= 50.0), 32'd1);
            mem[int'(sram_addr)] = sram_dq_out;
        end
    end

    // Half-ns poll: RAM output timing and lane contention.
    initial begin
        #0.5;
        forever begin
            logic [7:0] v;
            v = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 8'h00;
            ram_drv = model_on && (rd_act || ($realtime - t_rd_off < 20.0));
            if (rd_act && ($realtime - mx(0, 0) >= 0) &&
                ($realtime - ((t_addr > t_cs_fall) ? t_addr : t_cs_fall) >= 55.0) &&
                ($realtime - t_oe_fall >= 25.0))
                ram_dq = v;
            else
                ram_dq = ~v;
            if (ram_drv && sram_dq_oe) clash++;
            if (model_on && sram_dq_oe && !sram_oe_n) clash++;
            #0.5;
        end
    end

    // ---------------- Request driver ----------------
    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output int lat, output logic [DW-1:0] rd);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_done && lat < 100) begin @(negedge clk); lat++; end
        rd = rsp_rdata;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int lat; logic [DW-1:0] rd;
        issue(1'b1, a, d, lat, rd);
        chk("R9 write done latency", 32'(lat), 32'(E_WT + 1));
        ref_mem[int'(a)] = d;
        @(negedge clk);
        chk("R9 done single cycle", 32'(rsp_done), 32'd0);
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        int lat; logic [DW-1:0] rd; logic [DW-1:0] exp;
        exp = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
        issue(1'b0, a, 8'h00, lat, rd);
        chk("R2 read done latency", 32'(lat), 32'(E_RD + 1));
        chk("R3 read data", 32'(rd), 32'(exp));
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 cs_n", 32'(sram_cs_n), 32'd1);
        chk("R1 oe_n", 32'(sram_oe_n), 32'd1);
        chk("R1 we_n", 32'(sram_we_n), 32'd1);
        chk("R1 dq_oe", 32'(sram_dq_oe), 32'd0);
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 done", 32'(rsp_done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        model_on = 1;
        chk("R1 ready after release", 32'(req_ready), 32'd1);

        // R2: strobe levels inside a read phase
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 19'h00010;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 read cs_n", 32'(sram_cs_n), 32'd0);
        chk("R2 read oe_n", 32'(sram_oe_n), 32'd0);
        chk("R2 read we_n", 32'(sram_we_n), 32'd1);
        while (!rsp_done) @(negedge clk);

        // R4/R5: strobe levels in address and pulse phases
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00020; req_wdata = 8'h3C;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R5 driver off in address phase", 32'(sram_dq_oe), 32'd0);
        chk("R4 oe_n high in write", 32'(sram_oe_n), 32'd1);
        repeat (E_WA) @(negedge clk);
        chk("R4 we_n low in pulse", 32'(sram_we_n), 32'd0);
        chk("R5 driver on in pulse", 32'(sram_dq_oe), 32'd1);
        repeat (E_WP) @(negedge clk);
        chk("R5 driver still on after WE rise", {31'd0, sram_dq_oe & sram_we_n}, 32'd1);
        @(negedge clk);
        chk("R5 driver off cycle after WE rise", 32'(sram_dq_oe), 32'd0);
        ref_mem[32'h20] = 8'h3C;

        // Directed corners: lowest and highest address, back-to-back turns
        do_write(19'h00000, 8'hA1);
        do_write(19'h7FFFF, 8'h5E);
        do_read(19'h00000);
        do_read(19'h7FFFF);
        do_read(19'h00020);
        do_write(19'h00005, 8'hFF);   // R10 read then write
        do_read(19'h00005);           // R10 write then read
        do_read(19'h00005);           // read then read

        // R8: request while busy is ignored
        do_write(19'h00044, 8'h11);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00033; req_wdata = 8'h77;
        @(negedge clk);
        req_valid = 1'b0; req_addr = 19'h00044; req_wdata = 8'h99;
        @(negedge clk);
        req_valid = 1'b1;                       // raised mid-cycle
        chk("R8 ready low while busy", 32'(req_ready), 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_done) @(negedge clk);
        ref_mem[32'h33] = 8'h77;
        do_read(19'h00044);                     // R8 expects 8'h11
        do_read(19'h00033);

        // Seeded random traffic over a small address pool
        for (int i = 0; i < 80; i++) begin
            logic [AW-1:0] a;
            a = {($urandom() % 2 == 0) ? 11'h7FF : 11'h000, 8'($urandom() % 16)};
            if ($urandom() % 2 == 0) do_write(a, 8'($urandom()));
            else                     do_read(a);
        end

        repeat (4) @(negedge clk);
        chk("R10 no lane contention events", 32'(clash), 32'd0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule